// File: doc/BRIEF.md
# Request Header and Payload Merger

This block joins two independent request streams into one packet stream. A header stream carries request headers, each flagged as a read or a write. A data stream carries write payload frames delimited by start and end markers. On the output, every read header leaves as a packet of exactly one beat. Every write header leaves as the first beat of a packet whose remaining beats are the payload frame paired with it.

Payload frames can need many cycles to load. The block therefore holds a write header back until the last beat of its frame has been accepted. Once a write packet starts, it streams without bubbles caused by missing payload. Headers and frames pair strictly in arrival order. Write headers wait in their own queue, so a read header arriving behind a stalled write is not blocked by it. The payload sits in a buffer, and a count of complete frames in that buffer decides when a write may go.

The output is registered and follows a valid/ready handshake. The header sits in the low bits of the output beat, and the upper bits are zero.

Top module: `hdm_merger`

## Requirements
- R1: After reset the output valid is low, and both input ready signals are high while nothing is buffered.
- R2: A read header (hdrWrite = 0) produces one output beat with outSof = 1 and outEof = 1. outData carries the header in bits HDR_W-1:0 and zeros above.
- R3: No part of a write packet appears on the output before the beat with dataEof = 1 of its paired payload frame has been accepted.
- R4: A write packet is a header beat (outSof = 1, outEof = 0, header zero-extended as in R2) followed by the payload beats in input order, each with outSof = 0. outEof = 1 is set only on the last of them. Input frames mark their first beat with dataSof = 1 and their last with dataEof = 1.
- R5: The n-th write header is paired with the n-th payload frame, and write packets leave in the order of their headers.
- R6: A read header can leave ahead of an earlier write header that is still waiting for its payload. Read packets keep their order among themselves.
- R7: While outValid = 1 and outReady = 0, outValid, outData, outSof and outEof do not change.
- R8: The payload buffer holds PAY_DEPTH beats, and dataReady is low while it is full. A frame may be up to PAY_DEPTH beats long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdrValid | input | 1 | Header present |
| hdrReady | output | 1 | Header accepted when high together with hdrValid |
| hdrWrite | input | 1 | 1 = write request, 0 = read request |
| hdrData | input | HDR_W | Request header |
| dataValid | input | 1 | Payload beat present |
| dataReady | output | 1 | Payload beat accepted when high together with dataValid |
| dataSof | input | 1 | First beat of a payload frame |
| dataEof | input | 1 | Last beat of a payload frame |
| dataData | input | DATA_W | Payload beat |
| outValid | output | 1 | Output beat present |
| outReady | input | 1 | Downstream accepts the beat |
| outSof | output | 1 | First beat of a packet |
| outEof | output | 1 | Last beat of a packet |
| outData | output | DATA_W | Output beat |

## Verification
The bench feeds a payload frame slowly after its write header. It watches for any output before the final beat, which is what a design that released headers on the first payload beat would produce. It parks a write header with no payload and then sends a read. A design that queued reads behind writes would hold that read back. It also sends several write headers before their frames, so swapped pairing or reordered writes show up as mismatched header beats. Finally it fills the payload buffer to its exact depth while the output is stalled. An off-by-one in the full flag, or an output register that loads while stalled, shows up as a ready that stays high or as data that changes under backpressure.

// File: rtl/hdm_pkg.sv
package hdm_pkg;

  // Strobes from the control to the datapath, one per action in a cycle
  typedef struct packed {
    logic pushWrHdr;
    logic popWrHdr;
    logic pushPay;
    logic popPay;
    logic loadWrHdr;
    logic loadRdHdr;
    logic loadPay;
  } hdm_ctrl_t;

  // Datapath state seen by the control
  typedef struct packed {
    logic wrQEmpty;
    logic wrQFull;
    logic payEmpty;
    logic payFull;
    logic payHeadEof;
    logic outValid;
  } hdm_stat_t;

  typedef enum logic {
    ST_IDLE,
    ST_PAY
  } hdm_state_t;

endpackage

// File: rtl/hdm_fifo.sv
// Synchronous FIFO; DEPTH must be a power of two and at least 2
module hdm_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;
  logic [AW:0]      cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (!push && pop) cnt <= cnt - 1'b1;
    end
  end

  assign dout  = mem[rdPtr];
  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty); // R4

endmodule

// File: rtl/hdm_datapath.sv
module hdm_datapath
  import hdm_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int HDR_W     = 24,
  parameter int PAY_DEPTH = 16,
  parameter int WQ_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  hdm_ctrl_t         ctrl,
  input  logic [HDR_W-1:0]  hdrData,
  input  logic [DATA_W-1:0] dataData,
  input  logic              dataEof,
  input  logic              outReady,
  output hdm_stat_t         stat,
  output logic              outValid,
  output logic              outSof,
  output logic              outEof,
  output logic [DATA_W-1:0] outData
);
  localparam int PAY_W = DATA_W + 1;

  logic [HDR_W-1:0] wrHead;
  logic             wrEmpty;
  logic             wrFull;
  logic [PAY_W-1:0] payHead;
  logic             payEmpty;
  logic             payFull;

  logic              outValidQ;
  logic              outSofQ;
  logic              outEofQ;
  logic [DATA_W-1:0] outDataQ;

  // Write headers waiting for their payload frame
  hdm_fifo #(.WIDTH(HDR_W), .DEPTH(WQ_DEPTH)) uWrQ (
    .clk  (clk),
    .rstN (rstN),
    .push (ctrl.pushWrHdr),
    .din  (hdrData),
    .pop  (ctrl.popWrHdr),
    .dout (wrHead),
    .empty(wrEmpty),
    .full (wrFull)
  );

  // Payload beats with their end marker in the top bit
  hdm_fifo #(.WIDTH(PAY_W), .DEPTH(PAY_DEPTH)) uPayQ (
    .clk  (clk),
    .rstN (rstN),
    .push (ctrl.pushPay),
    .din  ({dataEof, dataData}),
    .pop  (ctrl.popPay),
    .dout (payHead),
    .empty(payEmpty),
    .full (payFull)
  );

  // Output register: loads only when empty or being consumed
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValidQ <= 1'b0;
      outSofQ   <= 1'b0;
      outEofQ   <= 1'b0;
      outDataQ  <= '0;
    end else if (ctrl.loadWrHdr) begin
      outValidQ <= 1'b1;
      outSofQ   <= 1'b1;
      outEofQ   <= 1'b0;
      outDataQ  <= DATA_W'(wrHead);
    end else if (ctrl.loadRdHdr) begin
      outValidQ <= 1'b1;
      outSofQ   <= 1'b1;
      outEofQ   <= 1'b1;
      outDataQ  <= DATA_W'(hdrData);
    end else if (ctrl.loadPay) begin
      outValidQ <= 1'b1;
      outSofQ   <= 1'b0;
      outEofQ   <= payHead[DATA_W];
      outDataQ  <= payHead[DATA_W-1:0];
    end else if (outReady) begin
      outValidQ <= 1'b0;
    end
  end

  always_comb begin
    stat.wrQEmpty   = wrEmpty;
    stat.wrQFull    = wrFull;
    stat.payEmpty   = payEmpty;
    stat.payFull    = payFull;
    stat.payHeadEof = payHead[DATA_W];
    stat.outValid   = outValidQ;
  end

  assign outValid = outValidQ;
  assign outSof   = outSofQ;
  assign outEof   = outEofQ;
  assign outData  = outDataQ;

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValidQ && !outReady) |=> (outValidQ && $stable(outDataQ)
      && $stable(outSofQ) && $stable(outEofQ))); // R7

endmodule

// File: rtl/hdm_control.sv
module hdm_control
  import hdm_pkg::*;
#(
  parameter int PAY_DEPTH = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      hdrValid,
  input  logic      hdrWrite,
  input  logic      dataValid,
  input  logic      dataSof,
  input  logic      dataEof,
  input  logic      outReady,
  input  hdm_stat_t stat,
  output hdm_ctrl_t ctrl,
  output logic      hdrReady,
  output logic      dataReady
);
  localparam int CW = $clog2(PAY_DEPTH + 1);

  hdm_state_t state;
  logic [CW-1:0] frameCnt;
  logic midFrame;

  logic canLoad;
  logic relWr;
  logic ldRd;
  logic ldPay;
  logic payAcc;
  logic frameIn;

  always_comb begin
    canLoad   = !stat.outValid || outReady;
    relWr     = (state == ST_IDLE) && canLoad && !stat.wrQEmpty
                && (frameCnt != '0);
    hdrReady  = hdrWrite ? !stat.wrQFull
                         : ((state == ST_IDLE) && canLoad && !relWr);
    ldRd      = hdrValid && !hdrWrite && hdrReady;
    ldPay     = (state == ST_PAY) && canLoad && !stat.payEmpty;
    dataReady = !stat.payFull;
    payAcc    = dataValid && dataReady;
    frameIn   = payAcc && dataEof;

    ctrl.pushWrHdr = hdrValid && hdrWrite && !stat.wrQFull;
    ctrl.popWrHdr  = relWr;
    ctrl.pushPay   = payAcc;
    ctrl.popPay    = ldPay;
    ctrl.loadWrHdr = relWr;
    ctrl.loadRdHdr = ldRd;
    ctrl.loadPay   = ldPay;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else if (relWr) begin
      state <= ST_PAY;
    end else if (ldPay && stat.payHeadEof) begin
      state <= ST_IDLE;
    end
  end

  // Complete frames held in the payload buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCnt <= '0;
    end else if (frameIn && !relWr) begin
      frameCnt <= frameCnt + 1'b1;
    end else if (!frameIn && relWr) begin
      frameCnt <= frameCnt - 1'b1;
    end
  end

  // Input framing tracker
  always_ff @(posedge clk) begin
    if (!rstN) begin
      midFrame <= 1'b0;
    end else if (payAcc) begin
      midFrame <= !dataEof;
    end
  end

  AST_PAY_COMPLETE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAY) |-> !stat.payEmpty); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    frameCnt <= CW'(PAY_DEPTH)); // R8
  AST_SOF_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    payAcc |-> (dataSof == !midFrame)); // R4

endmodule

// File: rtl/hdm_merger.sv
module hdm_merger
  import hdm_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int HDR_W     = 24,
  parameter int PAY_DEPTH = 16,
  parameter int WQ_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hdrValid,
  output logic              hdrReady,
  input  logic              hdrWrite,
  input  logic [HDR_W-1:0]  hdrData,
  input  logic              dataValid,
  output logic              dataReady,
  input  logic              dataSof,
  input  logic              dataEof,
  input  logic [DATA_W-1:0] dataData,
  output logic              outValid,
  input  logic              outReady,
  output logic              outSof,
  output logic              outEof,
  output logic [DATA_W-1:0] outData
);
  hdm_ctrl_t ctrl;
  hdm_stat_t stat;

  hdm_control #(.PAY_DEPTH(PAY_DEPTH)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .hdrValid (hdrValid),
    .hdrWrite (hdrWrite),
    .dataValid(dataValid),
    .dataSof  (dataSof),
    .dataEof  (dataEof),
    .outReady (outReady),
    .stat     (stat),
    .ctrl     (ctrl),
    .hdrReady (hdrReady),
    .dataReady(dataReady)
  );

  hdm_datapath #(
    .DATA_W   (DATA_W),
    .HDR_W    (HDR_W),
    .PAY_DEPTH(PAY_DEPTH),
    .WQ_DEPTH (WQ_DEPTH)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .hdrData (hdrData),
    .dataData(dataData),
    .dataEof (dataEof),
    .outReady(outReady),
    .stat    (stat),
    .outValid(outValid),
    .outSof  (outSof),
    .outEof  (outEof),
    .outData (outData)
  );

endmodule

// File: tb/hdm_merger_bench.sv
module hdm_merger_bench;
  localparam int DW = 32;
  localparam int HW = 24;
  localparam int PD = 16;
  localparam int WD = 4;
  localparam int BW = DW + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hdrValid = 1'b0, hdrWrite = 1'b0, hdrReady;
  logic [HW-1:0] hdrData = '0;
  logic dataValid = 1'b0, dataSof = 1'b0, dataEof = 1'b0, dataReady;
  logic [DW-1:0] dataData = '0;
  logic outValid, outSof, outEof;
  logic outReady = 1'b0;
  logic [DW-1:0] outData;

  always #10 clk = ~clk;

  hdm_merger #(.DATA_W(DW), .HDR_W(HW), .PAY_DEPTH(PD), .WQ_DEPTH(WD)) u_hdm_merger (
    .clk(clk), .rstN(rstN),
    .hdrValid(hdrValid), .hdrReady(hdrReady), .hdrWrite(hdrWrite), .hdrData(hdrData),
    .dataValid(dataValid), .dataReady(dataReady), .dataSof(dataSof), .dataEof(dataEof),
    .dataData(dataData),
    .outValid(outValid), .outReady(outReady), .outSof(outSof), .outEof(outEof),
    .outData(outData)
  );

  int checks = 0;
  int errors = 0;
  int framesDone = 0;
  int wrHdrsSeen = 0;
  int rdyMode = 0;
  bit randGaps = 1'b0;

  logic [BW-1:0] wrBeatQ[$];   // expected write packet beats {sof,eof,data}
  logic [DW-1:0] readQ[$];     // expected read packet beats
  logic [HW:0]   hdrPlanQ[$];  // {write, header}
  logic [BW-1:0] payPlanQ[$];  // {sof,eof,data}

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] mkBeat(logic s, logic e, logic [DW-1:0] d);
    return {s, e, d};
  endfunction

  function automatic logic [DW-1:0] extHdr(logic [HW-1:0] h);
    return DW'(h);
  endfunction

  function automatic void planWrite(logic [HW-1:0] h, int len);
    hdrPlanQ.push_back({1'b1, h});
    wrBeatQ.push_back(mkBeat(1'b1, 1'b0, extHdr(h)));
    for (int i = 0; i < len; i++) begin
      logic [DW-1:0] d;
      d = $urandom;
      payPlanQ.push_back(mkBeat(i == 0, i == len - 1, d));
      wrBeatQ.push_back(mkBeat(1'b0, i == len - 1, d));
    end
  endfunction

  function automatic void planRead(logic [HW-1:0] h);
    hdrPlanQ.push_back({1'b0, h});
    readQ.push_back(extHdr(h));
  endfunction

  task automatic sendHdr();
    logic [HW:0] p;
    p = hdrPlanQ.pop_front();
    @(posedge clk); #2;
    hdrValid = 1'b1; hdrWrite = p[HW]; hdrData = p[HW-1:0];
    do @(negedge clk); while (!hdrReady);
    @(posedge clk); #2;
    hdrValid = 1'b0;
  endtask

  task automatic sendBeat();
    logic [BW-1:0] b;
    b = payPlanQ.pop_front();
    @(posedge clk); #2;
    dataValid = 1'b1; {dataSof, dataEof, dataData} = b;
    do @(negedge clk); while (!dataReady);
    @(posedge clk);
    if (b[DW]) framesDone++;
    #2 dataValid = 1'b0;
  endtask

  task automatic hdrDriver();
    while (hdrPlanQ.size() > 0) begin
      sendHdr();
      if (randGaps) repeat ($urandom % 3) @(posedge clk);
    end
  endtask

  task automatic payDriver();
    while (payPlanQ.size() > 0) begin
      sendBeat();
      if (randGaps) repeat ($urandom % 3) @(posedge clk);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Ready pattern
  initial forever begin
    @(posedge clk); #2;
    case (rdyMode)
      0: outReady = 1'b1;
      1: outReady = ($urandom % 4) != 0;
      default: outReady = 1'b0;
    endcase
  end

  // Output monitor
  bit inWr = 1'b0;
  bit prevStall = 1'b0;
  logic [BW-1:0] prevOut = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall)
        check(outValid && {outSof, outEof, outData} == prevOut, "R7", "held beat",
              {outValid, outSof, outEof, outData}, {1'b1, prevOut});
      prevStall = outValid && !outReady;
      prevOut = {outSof, outEof, outData};
      if (outValid && outReady) begin
        if (inWr) begin
          logic [BW-1:0] e;
          e = (wrBeatQ.size() > 0) ? wrBeatQ.pop_front() : '1;
          check({outSof, outEof, outData} == e, "R4", "payload beat",
                {outSof, outEof, outData}, e);
          if (outEof) inWr = 1'b0;
        end else if (outSof && outEof) begin
          logic [DW-1:0] e;
          e = (readQ.size() > 0) ? readQ.pop_front() : '1;
          check(outData == e, "R2", "read beat", outData, e);
        end else if (outSof) begin
          logic [BW-1:0] e;
          e = (wrBeatQ.size() > 0) ? wrBeatQ.pop_front() : '1;
          check({outSof, outEof, outData} == e, "R5", "write header beat",
                {outSof, outEof, outData}, e);
          check(wrHdrsSeen < framesDone, "R3", "header before full frame",
                wrHdrsSeen, framesDone);
          wrHdrsSeen++;
          inWr = 1'b1;
        end else begin
          check(1'b0, "R4", "beat outside packet", {outSof, outEof, outData}, 0);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "ALL", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    void'($urandom(32'd2024));
    rdyMode = 0;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    check(!outValid, "R1", "outValid after reset", outValid, 0);
    check(hdrReady, "R1", "hdrReady after reset", hdrReady, 1);
    check(dataReady, "R1", "dataReady after reset", dataReady, 1);

    // R2: single read
    planRead(24'hABCDEF);
    sendHdr();
    repeat (4) @(negedge clk);
    check(readQ.size() == 0, "R2", "read packet emitted", readQ.size(), 0);

    // R3: slow payload, nothing may leave before the last beat
    planWrite(24'h0A0B0C, 3);
    sendHdr();
    for (int i = 0; i < 3; i++) begin
      sendBeat();
      if (i < 2) begin
        repeat (5) @(negedge clk);
        check(!outValid, "R3", "output while frame incomplete", outValid, 0);
      end
    end
    repeat (10) @(negedge clk);
    check(wrBeatQ.size() == 0, "R4", "write packet drained", wrBeatQ.size(), 0);

    // R6: read overtakes a write waiting for payload
    planWrite(24'h111111, 2);
    planRead(24'h222222);
    sendHdr();
    sendHdr();
    repeat (4) @(negedge clk);
    check(readQ.size() == 0, "R6", "read passed waiting write", readQ.size(), 0);
    check(wrBeatQ.size() == 3, "R6", "write still withheld", wrBeatQ.size(), 3);
    sendBeat();
    sendBeat();
    repeat (10) @(negedge clk);
    check(wrBeatQ.size() == 0, "R6", "write drained after payload", wrBeatQ.size(), 0);

    // R8: fill buffer to depth with output stalled
    rdyMode = 2;
    planWrite(24'h333333, PD);
    for (int i = 0; i < PD; i++) sendBeat();
    @(negedge clk);
    check(!dataReady, "R8", "dataReady with buffer full", dataReady, 0);
    sendHdr();
    repeat (4) @(negedge clk);
    check(outValid && outSof && !outEof, "R7", "header held under stall",
          {outValid, outSof, outEof}, 3'b110);
    rdyMode = 1;
    repeat (80) @(negedge clk);
    check(wrBeatQ.size() == 0, "R8", "full frame delivered", wrBeatQ.size(), 0);
    check(dataReady, "R8", "dataReady after drain", dataReady, 1);

    // R5: headers ahead of their frames
    planWrite(24'h444444, 2);
    planWrite(24'h555555, 1);
    sendHdr();
    sendHdr();
    for (int i = 0; i < 3; i++) sendBeat();
    repeat (20) @(negedge clk);
    check(wrBeatQ.size() == 0, "R5", "paired writes drained", wrBeatQ.size(), 0);

    // Random traffic
    randGaps = 1'b1;
    for (int i = 0; i < 120; i++) begin
      if ($urandom % 2) planWrite(HW'($urandom), 1 + ($urandom % 6));
      else planRead(HW'($urandom));
    end
    fork
      hdrDriver();
      payDriver();
    join
    repeat (300) @(negedge clk);
    check(wrBeatQ.size() == 0, "R5", "random writes drained", wrBeatQ.size(), 0);
    check(readQ.size() == 0, "R6", "random reads drained", readQ.size(), 0);
    check(!inWr, "R4", "no open packet at end", inWr, 0);
    finishRun();
  end

endmodule